// File: doc/BRIEF.md
# Paged Host Register Port for a Time-Slot Switch

This block sits between a small microprocessor bus and the internal memories of a time-slot switch. The host sees only 64 byte addresses. The lower half of that space is one 8-bit control register; all 32 addresses in the lower half reach the same register. The upper half is a 32-byte window. Each byte in the window is one channel of one serial stream, in one of three internal memories.

The control register chooses what the window shows. Its low three bits name the stream. Its next two bits name the memory: the data memory (read only), the high connection memory or the low connection memory. Control register accesses finish in the cycle they are accepted. A window access starts a request on the memory-side port. The block then reports busy until the memory acknowledges. The block does not contain the memories.

Top module: `tsw_hpi`

## Requirements
- R1: After reset the control register is 0, `busy` is low, neither memory request is raised and `rdata` is 0.
- R2: An accepted write with `addr[5]`=0 loads `wdata` into the control register at that clock edge, whatever `addr[4:0]` holds, and raises no busy.
- R3: An accepted read with `addr[5]`=0 puts all eight control register bits, bits 7 to 5 included, on `rdata` after that edge, with no busy.
- R4: An accepted window access (`addr[5]`=1) presents `mem_chan` = `addr[4:0]` and `mem_stream` = control bits 2:0.
- R5: Control bits 4:3 pick the memory. 00 and 01 pick the data memory (`mem_sel`=00). 10 picks the high connection memory (`mem_sel`=10). 11 picks the low connection memory (`mem_sel`=11).
- R6: A window access holds one request, with stable selectors, and holds `busy` high from the accepting edge until the edge at which `mem_ack` is seen. With an acknowledge on the second request cycle, busy lasts exactly 2 cycles.
- R7: A window read captures `mem_rdata` into `rdata` at the acknowledging edge.
- R8: A window write to a connection memory raises `mem_wr_req` and carries the host `wdata` on `mem_wdata`.
- R9: A window write while the data memory is selected is dropped. No request is raised and busy stays low.
- R10: Any strobe that arrives while busy is high is ignored, including on the acknowledging cycle.
- R11: When `rd` and `wr` are high together, the access is a write.
- R12: With `sel` low, strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 6 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| busy | output | 1 | Slow access in progress (ready low) |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_sel | output | 2 | Memory select: 00 data, 10 high connection, 11 low connection |
| mem_stream | output | 3 | Stream index |
| mem_chan | output | 5 | Channel index |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The end of a slow access and the next host strobe can fall in the same cycle. At the acknowledging edge the block is still busy, so a strobe presented there must be dropped and must not start a new access. The bench holds a control register write strobe across the whole busy window, acknowledging cycle included, while a window read is in flight. It then judges by reading the control register back through the host port, and by checking that no second memory request appears after the acknowledge.

// File: rtl/tsw_hpi_pkg.sv
package tsw_hpi_pkg;

    typedef enum logic [1:0] {
        MEM_DATA = 2'b00,
        MEM_CHI  = 2'b10,
        MEM_CLO  = 2'b11
    } mem_sel_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_st_e;

endpackage

// File: rtl/tsw_hpi_decode.sv
module tsw_hpi_decode
    import tsw_hpi_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int STREAM_W = 3
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [STREAM_W+1:0] page,
    output logic                is_ctrl,
    output logic [ADDR_W-2:0]   chan,
    output logic [STREAM_W-1:0] stream,
    output mem_sel_e            msel
);
    localparam int CHAN_W = ADDR_W - 1;

    logic [1:0] mem_field;

    always_comb begin
        is_ctrl   = ~addr[ADDR_W-1];
        chan      = addr[CHAN_W-1:0];
        stream    = page[STREAM_W-1:0];
        mem_field = page[STREAM_W+1:STREAM_W];
        case (mem_field)
            2'b10:   msel = MEM_CHI;
            2'b11:   msel = MEM_CLO;
            default: msel = MEM_DATA;
        endcase
    end

endmodule

// File: rtl/tsw_hpi_ctrl.sv
module tsw_hpi_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.val = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value = s_q.val;

endmodule

// File: rtl/tsw_hpi_seq.sv
module tsw_hpi_seq
    import tsw_hpi_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STREAM_W = 3,
    parameter int CHAN_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rd,
    input  logic                wr,
    input  logic                is_ctrl,
    input  mem_sel_e            msel,
    input  logic [STREAM_W-1:0] stream,
    input  logic [CHAN_W-1:0]   chan,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   ctrl_val,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic                ctrl_we,
    output logic                busy,
    output logic                rd_req,
    output logic                wr_req,
    output mem_sel_e            mem_sel,
    output logic [STREAM_W-1:0] mem_stream,
    output logic [CHAN_W-1:0]   mem_chan,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W-1:0]   rdata
);
    typedef struct packed {
        seq_st_e             st;
        logic                rd_req;
        logic                wr_req;
        mem_sel_e            msel;
        logic [STREAM_W-1:0] stream;
        logic [CHAN_W-1:0]   chan;
        logic [DATA_W-1:0]   wdat;
        logic [DATA_W-1:0]   rdat;
    } seq_t;

    seq_t s_d, s_q;
    logic go;
    logic go_wr;

    always_comb begin
        s_d     = s_q;
        ctrl_we = 1'b0;
        go      = sel && (rd || wr) && (s_q.st == SEQ_IDLE);
        go_wr   = wr;
        case (s_q.st)
            SEQ_IDLE: begin
                if (go) begin
                    if (is_ctrl) begin
                        if (go_wr) begin
                            ctrl_we = 1'b1;
                        end else begin
                            s_d.rdat = ctrl_val;
                        end
                    end else if (go_wr) begin
                        if (msel != MEM_DATA) begin
                            s_d.st     = SEQ_WAIT;
                            s_d.wr_req = 1'b1;
                            s_d.msel   = msel;
                            s_d.stream = stream;
                            s_d.chan   = chan;
                            s_d.wdat   = wdata;
                        end
                    end else begin
                        s_d.st     = SEQ_WAIT;
                        s_d.rd_req = 1'b1;
                        s_d.msel   = msel;
                        s_d.stream = stream;
                        s_d.chan   = chan;
                    end
                end
            end
            SEQ_WAIT: begin
                if (mem_ack) begin
                    s_d.st     = SEQ_IDLE;
                    s_d.rd_req = 1'b0;
                    s_d.wr_req = 1'b0;
                    if (s_q.rd_req) begin
                        s_d.rdat = mem_rdata;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= SEQ_IDLE;
            s_q.msel <= MEM_DATA;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st == SEQ_WAIT);
    assign rd_req     = s_q.rd_req;
    assign wr_req     = s_q.wr_req;
    assign mem_sel    = s_q.msel;
    assign mem_stream = s_q.stream;
    assign mem_chan   = s_q.chan;
    assign mem_wdata  = s_q.wdat;
    assign rdata      = s_q.rdat;

endmodule

// File: rtl/tsw_hpi.sv
module tsw_hpi
    import tsw_hpi_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int STREAM_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rd,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                busy,
    output logic                mem_rd_req,
    output logic                mem_wr_req,
    output logic [1:0]          mem_sel,
    output logic [STREAM_W-1:0] mem_stream,
    output logic [ADDR_W-2:0]   mem_chan,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ack
);
    localparam int CHAN_W = ADDR_W - 1;
    localparam int PAGE_W = STREAM_W + 2;

    logic [DATA_W-1:0]   ctrl_val;
    logic                ctrl_we;
    logic                is_ctrl;
    logic [CHAN_W-1:0]   dec_chan;
    logic [STREAM_W-1:0] dec_stream;
    mem_sel_e            dec_msel;
    mem_sel_e            seq_msel;

    tsw_hpi_decode #(
        .ADDR_W  (ADDR_W),
        .STREAM_W(STREAM_W)
    ) u_decode (
        .addr   (addr),
        .page   (ctrl_val[PAGE_W-1:0]),
        .is_ctrl(is_ctrl),
        .chan   (dec_chan),
        .stream (dec_stream),
        .msel   (dec_msel)
    );

    tsw_hpi_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ctrl_we),
        .wdata(wdata),
        .value(ctrl_val)
    );

    tsw_hpi_seq #(
        .DATA_W  (DATA_W),
        .STREAM_W(STREAM_W),
        .CHAN_W  (CHAN_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rd        (rd),
        .wr        (wr),
        .is_ctrl   (is_ctrl),
        .msel      (dec_msel),
        .stream    (dec_stream),
        .chan      (dec_chan),
        .wdata     (wdata),
        .ctrl_val  (ctrl_val),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .ctrl_we   (ctrl_we),
        .busy      (busy),
        .rd_req    (mem_rd_req),
        .wr_req    (mem_wr_req),
        .mem_sel   (seq_msel),
        .mem_stream(mem_stream),
        .mem_chan  (mem_chan),
        .mem_wdata (mem_wdata),
        .rdata     (rdata)
    );

    assign mem_sel = seq_msel;

endmodule

// File: rtl/tsw_hpi_chk.sv
module tsw_hpi_chk #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int STREAM_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel,
    input logic                rd,
    input logic                wr,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic                busy,
    input logic                mem_rd_req,
    input logic                mem_wr_req,
    input logic [1:0]          mem_sel,
    input logic [STREAM_W-1:0] mem_stream,
    input logic [ADDR_W-2:0]   mem_chan,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic [DATA_W-1:0]   mem_rdata,
    input logic                mem_ack,
    input logic [DATA_W-1:0]   ctrl_val
);
    logic any_req;
    logic idle_hit;
    assign any_req  = mem_rd_req || mem_wr_req;
    assign idle_hit = sel && !busy;

    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> busy);

    assert_one_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_req, mem_wr_req}));

    assert_req_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !mem_ack) |=> (any_req && $stable(mem_sel) && $stable(mem_stream)
                                   && $stable(mem_chan) && $stable(mem_wdata)));

    assert_ctrl_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && wr && !addr[ADDR_W-1]) |=> (ctrl_val == $past(wdata)) && !busy);

    assert_ctrl_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && rd && !wr && !addr[ADDR_W-1]) |=> (rdata == $past(ctrl_val)) && !busy);

    assert_chan_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && rd && !wr && addr[ADDR_W-1]) |=>
            (mem_rd_req && mem_chan == $past(addr[ADDR_W-2:0])
             && mem_stream == $past(ctrl_val[STREAM_W-1:0])));

    assert_read_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_ack) |=> (rdata == $past(mem_rdata)) && !busy);

    assert_dm_wr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && wr && addr[ADDR_W-1] && !ctrl_val[STREAM_W+1]) |=>
            (!busy && !mem_wr_req && !mem_rd_req));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_val));

    assert_no_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !busy) |=> ($stable(ctrl_val) && !busy));

endmodule

bind tsw_hpi tsw_hpi_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STREAM_W(STREAM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd        (rd),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .busy      (busy),
    .mem_rd_req(mem_rd_req),
    .mem_wr_req(mem_wr_req),
    .mem_sel   (mem_sel),
    .mem_stream(mem_stream),
    .mem_chan  (mem_chan),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .ctrl_val  (ctrl_val)
);

// File: tb/tsw_hpi_tb.sv
module tsw_hpi_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, rd, wr;
    logic [5:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       busy, mem_rd_req, mem_wr_req;
    logic [1:0] mem_sel;
    logic [2:0] mem_stream;
    logic [4:0] mem_chan;
    logic [7:0] mem_wdata, mem_rdata;
    logic       mem_ack;

    always #5 clk = ~clk;

    tsw_hpi u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_wr_req(mem_wr_req), .mem_sel(mem_sel), .mem_stream(mem_stream),
        .mem_chan(mem_chan), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // memory model: acknowledges on the second request cycle
    logic [7:0] m_hi [256];
    logic [7:0] m_lo [256];
    logic [7:0] m_dat[256];
    logic [1:0] ack_cnt;
    logic       req;
    logic [7:0] idx;
    assign req     = mem_rd_req | mem_wr_req;
    assign idx     = {mem_stream, mem_chan};
    assign mem_ack = req && (ack_cnt == 2'd1);
    assign mem_rdata = (mem_sel == 2'b10) ? m_hi[idx] :
                       (mem_sel == 2'b11) ? m_lo[idx] : m_dat[idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_cnt <= 2'd0;
        end else if (mem_ack) begin
            ack_cnt <= 2'd0;
            if (mem_wr_req && mem_sel == 2'b10) m_hi[idx] <= mem_wdata;
            if (mem_wr_req && mem_sel == 2'b11) m_lo[idx] <= mem_wdata;
        end else if (req) begin
            ack_cnt <= ack_cnt + 2'd1;
        end
    end

    // reference state
    logic [7:0] r_hi[256];
    logic [7:0] r_lo[256];
    logic [7:0] ctrl_ref;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    function automatic logic [7:0] dat_init(int i);
        return 8'(i * 7 + 3) ^ 8'hA5;
    endfunction

    function automatic logic [1:0] exp_sel(logic [1:0] page);
        return (page == 2'b10) ? 2'b10 : (page == 2'b11) ? 2'b11 : 2'b00;
    endfunction

    function automatic logic [7:0] exp_mem(logic [1:0] page, logic [2:0] s, logic [4:0] c);
        if (page == 2'b10) return r_hi[{s, c}];
        if (page == 2'b11) return r_lo[{s, c}];
        return dat_init(int'({s, c}));
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // observed port values of the last access
    logic       o_rd, o_wr;
    logic [1:0] o_sel;
    logic [2:0] o_str;
    logic [4:0] o_ch;
    logic [7:0] o_wd;
    logic [7:0] o_rdata;
    int         o_busy;

    task automatic access(bit do_rd, bit do_wr, logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd = do_rd; wr = do_wr; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; wr = 1'b0;
        o_rd = mem_rd_req; o_wr = mem_wr_req; o_sel = mem_sel;
        o_str = mem_stream; o_ch = mem_chan; o_wd = mem_wdata;
        o_busy = 0;
        while (busy && o_busy < 10) begin
            o_busy++;
            @(negedge clk);
        end
        o_rdata = rdata;
    endtask

    task automatic ctrl_wr(logic [4:0] lo, logic [7:0] d);
        access(1'b0, 1'b1, {1'b0, lo}, d);
        ctrl_ref = d;
        check(o_busy == 0 && !o_rd && !o_wr, "R2 ctrl write no busy", o_busy, 0);
    endtask

    task automatic ctrl_rd(logic [4:0] lo, string tag);
        access(1'b1, 1'b0, {1'b0, lo}, 8'h00);
        check(o_rdata == ctrl_ref && o_busy == 0, tag, o_rdata, ctrl_ref);
    endtask

    task automatic mem_wr(logic [4:0] c, logic [7:0] d);
        logic [1:0] pg;
        logic [2:0] s;
        pg = ctrl_ref[4:3];
        s  = ctrl_ref[2:0];
        access(1'b0, 1'b1, {1'b1, c}, d);
        if (pg[1] == 1'b0) begin
            check(!o_wr && !o_rd && o_busy == 0, "R9 data memory write dropped",
                  {o_wr, o_rd, 8'(o_busy)}, 0);
        end else begin
            check(o_wr && !o_rd && o_sel == exp_sel(pg) && o_str == s && o_ch == c,
                  "R4/R5 write port fields", {o_wr, o_sel, o_str, o_ch}, {1'b1, exp_sel(pg), s, c});
            check(o_wd == d, "R8 write data", o_wd, d);
            check(o_busy == 2, "R6 busy length on write", o_busy, 2);
            if (pg == 2'b10) r_hi[{s, c}] = d;
            else             r_lo[{s, c}] = d;
        end
    endtask

    task automatic mem_rd(logic [4:0] c);
        logic [1:0] pg;
        logic [2:0] s;
        logic [7:0] e;
        pg = ctrl_ref[4:3];
        s  = ctrl_ref[2:0];
        e  = exp_mem(pg, s, c);
        access(1'b1, 1'b0, {1'b1, c}, 8'h00);
        check(o_rd && !o_wr && o_sel == exp_sel(pg) && o_str == s && o_ch == c,
              "R4/R5 read port fields", {o_rd, o_sel, o_str, o_ch}, {1'b1, exp_sel(pg), s, c});
        check(o_busy == 2, "R6 busy length on read", o_busy, 2);
        check(o_rdata == e, "R7 read data", o_rdata, e);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_dat[i] = dat_init(i);
            m_hi[i] = 8'h00; m_lo[i] = 8'h00;
            r_hi[i] = 8'h00; r_lo[i] = 8'h00;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; sel = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        ctrl_ref = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd_req && !mem_wr_req && rdata == 8'h00,
              "R1 reset outputs", {busy, mem_rd_req, mem_wr_req, rdata}, 0);
        ctrl_rd(5'h00, "R1 control resets to zero");

        // aliasing and upper bits
        ctrl_wr(5'h00, 8'hE5);
        ctrl_rd(5'h1F, "R2/R3 alias readback");
        ctrl_wr(5'h13, 8'hA0);
        ctrl_rd(5'h07, "R3 bits 7:5 kept");

        // high connection memory, stream 2, window edges
        ctrl_wr(5'h0A, 8'h12);
        mem_wr(5'd0, 8'h3C);
        mem_wr(5'd31, 8'hC3);
        mem_rd(5'd31);
        mem_rd(5'd0);

        // low connection memory, stream 7
        ctrl_wr(5'h01, 8'h1F);
        mem_wr(5'd0, 8'h77);
        mem_rd(5'd0);

        // data memory, both encodings
        ctrl_wr(5'h02, 8'h05);
        mem_rd(5'd5);
        mem_wr(5'd5, 8'hFF);
        mem_rd(5'd5);
        ctrl_wr(5'h02, 8'h0B);
        mem_rd(5'd9);

        // R10: strobe held through the whole busy window
        ctrl_wr(5'h00, 8'h10);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; wr = 1'b0; addr = 6'h20;
        @(negedge clk);
        rd = 1'b0; wr = 1'b1; addr = 6'h00; wdata = 8'hFF;
        @(negedge clk);
        check(busy, "R10 still busy on ack cycle", busy, 1);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        check(!busy && !mem_rd_req && !mem_wr_req, "R10 no new access after ack",
              {busy, mem_rd_req, mem_wr_req}, 0);
        ctrl_rd(5'h00, "R10 control untouched while busy");

        // R11: rd and wr together act as write
        access(1'b1, 1'b1, 6'h05, 8'h3A);
        ctrl_ref = 8'h3A;
        ctrl_rd(5'h00, "R11 both strobes write");

        // R12: no select
        @(negedge clk);
        sel = 1'b0; wr = 1'b1; addr = 6'h00; wdata = 8'h99;
        @(negedge clk);
        check(!busy, "R12 no busy without select", busy, 0);
        wr = 1'b0;
        ctrl_rd(5'h00, "R12 control untouched without select");

        // constrained random mix
        for (int k = 0; k < 300; k++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: ctrl_wr(5'($urandom), 8'($urandom));
                1: ctrl_rd(5'($urandom), "R3 random readback");
                2: mem_wr(5'($urandom), 8'($urandom));
                default: mem_rd(5'($urandom));
            endcase
        end

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R6 actual=hung expected=done");
        finish_run();
    end

endmodule